// File: doc/BRIEF.md
# Serial Converter Sequencer with Input Multiplexer Addressing

This block is the digital control core of a two-channel successive-approximation converter that a host drives over a three-wire serial link: an active-low select, a serial clock and a data-in line. While select is low, the block samples data-in on every rising clock edge. It discards zeros until the first one arrives and treats that one as the start marker. The two bits that follow form the input configuration. This configuration drives the channel and polarity controls of the analog front end. The block then waits half a clock so the selected input can settle.

After the settling gap, the block runs a binary search with one trial per rising edge. It presents a trial code to the converter's DAC and keeps or drops the trial bit according to a comparator input. Each decided bit goes out on the serial data-out line on the next falling edge, most significant bit first, after one driven leading zero. Data-out carries a separate enable so that a pad can place the line in high impedance. Raising select at any moment cancels the transaction.

Top module: `serial_adc_seq`

## Requirements
- R1: While `cs_n` is high, `sdo_oe` is 0. `mux_diff`, `mux_pos_sel` and `dac_code` are also 0. Raising `cs_n` clears all state at once, without waiting for a clock edge.
- R2: With `cs_n` low, `sdi` is sampled on rising `sclk` edges. The first 1 sampled is the start marker, and any number of 0s before it are ignored.
- R3: The first bit after the start marker is the mode bit: 1 selects single-ended and 0 selects differential. The second bit is the odd/sign bit. From the rising edge that latches the second bit until `cs_n` rises, `mux_diff` equals the inverse of the mode bit and `mux_pos_sel` equals the odd/sign bit. A value of 1 on `mux_pos_sel` makes channel 1 the positive input.
- R4: `sdo_oe` stays 0 until the falling edge that follows the latch of the odd/sign bit. On that falling edge, `sdo_oe` goes to 1 and `sdo` carries a 0 for one clock.
- R5: On each of the eight rising edges that follow the settling gap, `dac_code` is the bits kept so far with the bit under test set. The first trial is 0x80. A 1 on `cmp_hi` at that rising edge keeps the bit, and a 0 clears it.
- R6: After the leading zero, the eight result bits appear on `sdo`, one per falling edge and most significant bit first. Each bit is the comparator decision from the rising edge just before that falling edge.
- R7: Once the configuration has been captured, `sdi` has no effect on the result or on the multiplexer outputs.
- R8: On the falling edge after the least significant bit, `sdo_oe` returns to 0. It stays at 0 until `cs_n` rises.
- R9: If `cmp_hi` stays 0 for every trial, as it does for a differential input whose positive side is lower, the result shifted out is 0x00.
- R10: Raising `cs_n` during the search or the address phase cancels the transaction. The next low period begins with a fresh search for the start marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock. Rising edges sample, falling edges shift out |
| cs_n | input | 1 | Active-low select. When high, it acts as an asynchronous clear |
| sdi | input | 1 | Serial data in: leading zeros, start marker, mode bit, odd/sign bit |
| cmp_hi | input | 1 | Comparator result: 1 when the selected input is at or above the trial level |
| dac_code | output | RES_BITS | Trial code sent to the converter's DAC |
| mux_diff | output | 1 | 1 when the front end is set for differential input |
| mux_pos_sel | output | 1 | Selects the channel used as the positive input |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the data-out pad. 0 means high impedance |

## Verification
The hardest condition to reach from the ports is a cancellation that arrives after several result bits have already been decided. The state must then return cleanly to the start-marker search, without a stale configuration or stale kept bits leaking into the next transaction. To reach it, the stimulus starts a real conversion, lets a few falling edges shift bits out, raises select between edges, and checks the enable at once. It then runs a full conversion that begins with leading zeros, so that any leftover state would corrupt the result that the scoreboard expects. A second hard case is the differential input with the negative side higher. The bench produces it by giving channel 1 the larger value while channel 0 is selected as positive.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    // Phase of a transaction, advanced on rising serial clock edges.
    typedef enum logic [2:0] {
        ST_HUNT  = 3'd0,  // waiting for the start marker
        ST_MODE  = 3'd1,  // next bit is single-ended / differential
        ST_SIGN  = 3'd2,  // next bit is odd / sign
        ST_TRIAL = 3'd3,  // binary search in progress
        ST_TAIL  = 3'd4,  // last bit decided, being shifted out
        ST_HOLD  = 3'd5   // finished, idle until select rises
    } seq_state_e;

endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int RES_BITS = 8
) (
    input  logic                sclk,
    input  logic                cs_n,
    input  logic                sdi,
    input  logic                cmp_hi,
    output logic                cfg_valid,
    output logic                cfg_sgl,
    output logic                cfg_odd,
    output logic [RES_BITS-1:0] dac_code,
    output logic                shift_on,
    output logic                lead_slot,
    output logic                last_bit
);

    localparam int SW = (RES_BITS > 1) ? $clog2(RES_BITS) : 1;
    localparam int CW = $clog2(RES_BITS + 1);
    localparam logic [SW-1:0] TOP_STEP = SW'(RES_BITS - 1);

    typedef struct packed {
        seq_state_e          st;
        logic                sgl;
        logic                odd;
        logic [RES_BITS-1:0] kept;
        logic [SW-1:0]       step;
        logic [CW-1:0]       ndone;
        logic                dec;
    } ctrl_t;

    ctrl_t cur_q, nxt_d;

    // One-hot mask of the bit under test.
    logic [RES_BITS-1:0] step_mask;
    for (genvar g = 0; g < RES_BITS; g++) begin : g_mask
        assign step_mask[g] = (cur_q.step == SW'(g));
    end

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.st)
            ST_HUNT: begin
                if (sdi) nxt_d.st = ST_MODE;
            end
            ST_MODE: begin
                nxt_d.sgl = sdi;
                nxt_d.st  = ST_SIGN;
            end
            ST_SIGN: begin
                nxt_d.odd   = sdi;
                nxt_d.kept  = '0;
                nxt_d.step  = TOP_STEP;
                nxt_d.ndone = '0;
                nxt_d.st    = ST_TRIAL;
            end
            ST_TRIAL: begin
                if (cmp_hi) nxt_d.kept = cur_q.kept | step_mask;
                nxt_d.dec   = cmp_hi;
                nxt_d.ndone = cur_q.ndone + 1'b1;
                if (cur_q.step == '0) nxt_d.st = ST_TAIL;
                else                  nxt_d.step = cur_q.step - 1'b1;
            end
            ST_TAIL: nxt_d.st = ST_HOLD;
            ST_HOLD: nxt_d.st = ST_HOLD;
            default: nxt_d.st = ST_HUNT;
        endcase
    end

    always_ff @(posedge sclk or posedge cs_n) begin
        if (cs_n) begin
            cur_q <= '{st: ST_HUNT, sgl: 1'b0, odd: 1'b0, kept: '0,
                       step: '0, ndone: '0, dec: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign cfg_valid = (cur_q.st == ST_TRIAL) || (cur_q.st == ST_TAIL) || (cur_q.st == ST_HOLD);
    assign cfg_sgl   = cur_q.sgl;
    assign cfg_odd   = cur_q.odd;
    assign dac_code  = (cur_q.st == ST_TRIAL) ? (cur_q.kept | step_mask) : cur_q.kept;
    assign shift_on  = (cur_q.st == ST_TRIAL) || (cur_q.st == ST_TAIL);
    assign lead_slot = (cur_q.ndone == '0);
    assign last_bit  = cur_q.dec;

    // R5: the first trial after the configuration is the top bit alone.
    p_first_trial_r5: assert property (@(posedge sclk) disable iff (cs_n)
        (cur_q.st == ST_SIGN) |=> (dac_code == RES_BITS'(1) << (RES_BITS - 1)));

    // R5: each trial sets at most one new kept bit.
    p_one_bit_per_step_r5: assert property (@(posedge sclk) disable iff (cs_n)
        (cur_q.st == ST_TRIAL) |=> ($countones(cur_q.kept) <= $countones($past(cur_q.kept)) + 1));

    // R2: zeros during the hunt never leave the hunt.
    p_zeros_ignored_r2: assert property (@(posedge sclk) disable iff (cs_n)
        (cur_q.st == ST_HUNT && !sdi) |=> (cur_q.st == ST_HUNT));

    // R7: the captured configuration does not move during the search.
    p_cfg_frozen_r7: assert property (@(posedge sclk) disable iff (cs_n)
        (cur_q.st == ST_TRIAL) |=> ($stable(cur_q.sgl) && $stable(cur_q.odd)));

    // R8: once finished, the sequencer stays finished until select rises.
    p_hold_sticks_r8: assert property (@(posedge sclk) disable iff (cs_n)
        (cur_q.st == ST_HOLD) |=> (cur_q.st == ST_HOLD));

endmodule

// File: rtl/adc_seq_dout.sv
module adc_seq_dout (
    input  logic sclk,
    input  logic cs_n,
    input  logic shift_on,
    input  logic lead_slot,
    input  logic last_bit,
    output logic sdo,
    output logic sdo_oe
);

    typedef struct packed {
        logic oe;
        logic dat;
    } dout_t;

    dout_t out_q, out_d;

    always_comb begin
        out_d     = out_q;
        out_d.oe  = shift_on;
        out_d.dat = shift_on && !lead_slot && last_bit;
    end

    always_ff @(negedge sclk or posedge cs_n) begin
        if (cs_n) out_q <= '{oe: 1'b0, dat: 1'b0};
        else      out_q <= out_d;
    end

    assign sdo    = out_q.dat;
    assign sdo_oe = out_q.oe;

    // R4: the first driven slot of a frame carries a zero.
    p_lead_zero_r4: assert property (@(posedge sclk) disable iff (cs_n)
        (sdo_oe && !$past(sdo_oe)) |-> !sdo);

endmodule

// File: rtl/adc_seq_mux_dec.sv
module adc_seq_mux_dec (
    input  logic cfg_valid,
    input  logic cfg_sgl,
    input  logic cfg_odd,
    output logic mux_diff,
    output logic mux_pos_sel
);

    always_comb begin
        mux_diff    = 1'b0;
        mux_pos_sel = 1'b0;
        if (cfg_valid) begin
            mux_diff    = !cfg_sgl;
            mux_pos_sel = cfg_odd;
        end
    end

endmodule

// File: rtl/serial_adc_seq.sv
module serial_adc_seq #(
    parameter int RES_BITS = 8
) (
    input  logic                sclk,
    input  logic                cs_n,
    input  logic                sdi,
    input  logic                cmp_hi,
    output logic [RES_BITS-1:0] dac_code,
    output logic                mux_diff,
    output logic                mux_pos_sel,
    output logic                sdo,
    output logic                sdo_oe
);

    logic cfg_valid, cfg_sgl, cfg_odd;
    logic shift_on, lead_slot, last_bit;

    adc_seq_ctrl #(.RES_BITS(RES_BITS)) ctrl_i (
        .sclk      (sclk),
        .cs_n      (cs_n),
        .sdi       (sdi),
        .cmp_hi    (cmp_hi),
        .cfg_valid (cfg_valid),
        .cfg_sgl   (cfg_sgl),
        .cfg_odd   (cfg_odd),
        .dac_code  (dac_code),
        .shift_on  (shift_on),
        .lead_slot (lead_slot),
        .last_bit  (last_bit)
    );

    adc_seq_mux_dec mux_i (
        .cfg_valid   (cfg_valid),
        .cfg_sgl     (cfg_sgl),
        .cfg_odd     (cfg_odd),
        .mux_diff    (mux_diff),
        .mux_pos_sel (mux_pos_sel)
    );

    adc_seq_dout dout_i (
        .sclk      (sclk),
        .cs_n      (cs_n),
        .shift_on  (shift_on),
        .lead_slot (lead_slot),
        .last_bit  (last_bit),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe)
    );

endmodule

// File: tb/serial_adc_seq_tb_top.sv
module serial_adc_seq_tb_top;

    logic       sclk = 1'b0;
    logic       cs_n = 1'b1;
    logic       sdi  = 1'b0;
    logic       cmp_hi;
    logic [7:0] dac_code;
    logic       mux_diff, mux_pos_sel, sdo, sdo_oe;

    int n_run  = 0;
    int n_fail = 0;

    logic [7:0] ch0 = 8'd0, ch1 = 8'd0;
    logic [8:0] exp_q[$];

    always #5 sclk = ~sclk;

    serial_adc_seq dut_i (
        .sclk(sclk), .cs_n(cs_n), .sdi(sdi), .cmp_hi(cmp_hi),
        .dac_code(dac_code), .mux_diff(mux_diff), .mux_pos_sel(mux_pos_sel),
        .sdo(sdo), .sdo_oe(sdo_oe)
    );

    // Analog front end model: multiplexer plus ideal comparator.
    always_comb begin
        logic [7:0] vp, vn, vin;
        vp  = mux_pos_sel ? ch1 : ch0;
        vn  = mux_pos_sel ? ch0 : ch1;
        vin = mux_diff ? ((vp > vn) ? vp - vn : 8'd0) : vp;
        cmp_hi = (vin >= dac_code);
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: collects driven bits on falling edges and compares whole frames.
    int         mon_cnt = 0;
    logic [8:0] mon_frame = '0;
    always @(negedge sclk) begin
        #2;
        if (cs_n) begin
            mon_cnt = 0;
        end else if (sdo_oe) begin
            mon_frame = {mon_frame[7:0], sdo};
            mon_cnt++;
        end else if (mon_cnt > 0) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected frame", int'(mon_frame), 0);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                check(mon_cnt == 9 && mon_frame == e, "R6 frame", int'(mon_frame), int'(e));
            end
            mon_cnt = 0;
        end
    end

    function automatic logic [7:0] expect_val(bit sgl, bit odd, logic [7:0] a, logic [7:0] b);
        logic [7:0] p, n;
        p = odd ? b : a;
        n = odd ? a : b;
        if (sgl) return p;
        return (p > n) ? p - n : 8'd0;
    endfunction

    task automatic send_bit(input bit v);
        sdi = v;
        @(posedge sclk);
        @(negedge sclk);
        #1;
    endtask

    // abort_at < 0: complete; otherwise raise select after that many result slots.
    task automatic convert(input int nz, input bit sgl, input bit odd,
                           input logic [7:0] a, input logic [7:0] b,
                           input bit noise, input int abort_at);
        logic [7:0] ev;
        ch0 = a; ch1 = b;
        ev = expect_val(sgl, odd, a, b);
        @(negedge sclk); #1;
        cs_n = 1'b0;
        for (int i = 0; i < nz; i++) send_bit(1'b0);
        send_bit(1'b1);
        send_bit(sgl);
        sdi = odd;
        @(posedge sclk);
        #2;
        check(sdo_oe == 1'b0, "R4 enable low before settle slot", sdo_oe, 0);
        check(mux_diff == !sgl, "R3 mux_diff", mux_diff, !sgl);
        check(mux_pos_sel == odd, "R3 mux_pos_sel", mux_pos_sel, odd);
        check(dac_code == 8'h80, "R5 first trial", dac_code, 8'h80);
        if (abort_at < 0) exp_q.push_back({1'b0, ev});
        @(negedge sclk); #2;
        check(sdo_oe && !sdo, "R4 leading zero", {sdo_oe, sdo}, 2);
        for (int k = 0; k < 8; k++) begin
            sdi = noise ? ~sdi : 1'b0;   // R7: data-in toggles during the search
            if (abort_at == k) begin
                cs_n = 1'b1;
                #1;
                check(sdo_oe == 1'b0 && dac_code == 0 && !mux_diff && !mux_pos_sel,
                      "R10 abort clears", {sdo_oe, mux_diff, mux_pos_sel}, 0);
                sdi = 1'b0;
                return;
            end
            @(posedge sclk); #2;
            if (k == 0) begin
                logic [7:0] t;
                t = {ev[7], 7'b1000000};
                check(dac_code == t, "R5 second trial", dac_code, t);
            end
            @(negedge sclk); #1;
        end
        @(negedge sclk); #3;
        check(sdo_oe == 1'b0, "R8 enable drops after last bit", sdo_oe, 0);
        @(negedge sclk); #3;
        check(sdo_oe == 1'b0, "R8 enable stays low", sdo_oe, 0);
        cs_n = 1'b1;
        sdi  = 1'b0;
        #2;
        check(sdo_oe == 1'b0, "R1 idle after select rises", sdo_oe, 0);
    endtask

    bit wd_hit = 1'b0;
    initial begin
        #(200000 * 10);
        wd_hit = 1'b1;
    end

    initial begin
        fork
            begin
                #12;
                check(sdo_oe == 0 && dac_code == 0 && !mux_diff && !mux_pos_sel,
                      "R1 reset state", {sdo_oe, mux_diff, mux_pos_sel}, 0);
                // R2 immediate start marker, R3 single-ended channel 0
                convert(0, 1'b1, 1'b0, 8'hA5, 8'h3C, 1'b0, -1);
                // R2 leading zeros, R3 single-ended channel 1
                convert(5, 1'b1, 1'b1, 8'h11, 8'hC3, 1'b0, -1);
                // R3 differential, channel 0 positive; R7 noisy data-in
                convert(2, 1'b0, 1'b0, 8'hF0, 8'h31, 1'b1, -1);
                // R3 differential, channel 1 positive
                convert(1, 1'b0, 1'b1, 8'h20, 8'h9F, 1'b1, -1);
                // R9 negative differential yields zero
                convert(3, 1'b0, 1'b0, 8'h10, 8'h80, 1'b0, -1);
                // R6 extreme codes
                convert(0, 1'b1, 1'b0, 8'hFF, 8'h00, 1'b0, -1);
                // R10 abort mid-search, then a clean transaction
                convert(2, 1'b1, 1'b1, 8'h55, 8'hAA, 1'b0, 3);
                convert(4, 1'b1, 1'b1, 8'h55, 8'hAA, 1'b1, -1);
                // R10 abort during the address phase
                @(negedge sclk); #1;
                cs_n = 1'b0;
                send_bit(1'b1);
                send_bit(1'b1);
                cs_n = 1'b1;
                #1;
                check(sdo_oe == 0 && !mux_diff && !mux_pos_sel, "R10 abort in address",
                      {sdo_oe, mux_diff, mux_pos_sel}, 0);
                convert(3, 1'b0, 1'b1, 8'h07, 8'h80, 1'b0, -1);
                repeat (3) @(negedge sclk);
                #3;
                check(exp_q.size() == 0, "R6 all frames seen", exp_q.size(), 0);
            end
            begin
                wait (wd_hit);
                check(1'b0, "watchdog", 1, 0);
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule